// File: doc/BRIEF.md
# Dual-Lane Half-Precision Converter

This unit converts between IEEE-754 single precision and half precision, two lanes per operation. In pack mode it narrows two 32-bit floats and returns one 32-bit word that holds both 16-bit halves. In unpack mode it widens the two halves of one 32-bit word into two 32-bit floats. Narrowing rounds to nearest with ties to even. Widening is exact.

A per-operation policy input chooses whether half-precision subnormals are kept or flushed to a signed zero. This policy applies in both directions. A half subnormal is a normal number in single precision. Keep mode therefore still produces and accepts half subnormals, even in a system that flushes single-precision subnormals. Single-precision subnormal inputs always narrow to a signed half zero.

Operations enter through a valid/ready handshake into a single result register. The result appears in the cycle after acceptance. A new operation is accepted in the same cycle that the previous result drains.

Top module: `half_pack_unit`

## Requirements
- R1: Pack mode (`op_unpack_i`=0) narrows finite normal inputs with round-to-nearest-even, within 0.5 ULP. Lane `a_i` goes to `res_a_o[15:0]` and lane `b_i` goes to `res_a_o[31:16]`.
- R2: Unpack mode (`op_unpack_i`=1) widens `a_i[15:0]` into `res_a_o` and `a_i[31:16]` into `res_b_o`, with no error. `b_i` has no effect on the result.
- R3: With `keep_sub_i`=1, pack produces half subnormals (exponent field 0, nonzero fraction). Unpack widens every half subnormal to a normalized single-precision value.
- R4: With `keep_sub_i`=0, a pack result that is still subnormal after rounding becomes a zero of the input's sign. A half subnormal presented for unpack widens to a zero of its own sign.
- R5: A single-precision zero or subnormal input narrows to a half zero of the same sign under either policy.
- R6: A finite input whose rounded magnitude exceeds 65504 narrows to an infinity of the same sign. Infinities convert to infinities in both directions.
- R7: A NaN input gives a quiet NaN with its sign kept. When narrowing, the half fraction MSB (bit 9) is set and fraction bits 8:0 take input fraction bits 21:13. When widening, single fraction bit 22 is set and bits 21:13 take half fraction bits 8:0.
- R8: A rounding carry out of the fraction increments the exponent. A rounded-up half subnormal becomes the smallest normal half, 0x0400, under either policy.
- R9: In pack mode `res_b_o` is all zero.
- R10: While `out_valid_o`=1 and `out_ready_i`=0, the results and `out_valid_o` hold, and `in_ready_o` is 0.
- R11: An operation is accepted when `in_ready_o` is 1, which happens when the stage is empty or draining in that cycle. The result appears, with `out_valid_o`=1, on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation request |
| in_ready_o | output | 1 | Unit can accept an operation |
| op_unpack_i | input | 1 | 0: pack two singles, 1: unpack two halves |
| keep_sub_i | input | 1 | 1: keep half subnormals, 0: flush them to signed zero |
| a_i | input | 32 | Pack: lane-0 single. Unpack: word with two halves |
| b_i | input | 32 | Pack: lane-1 single. Unpack: unused |
| out_valid_o | output | 1 | Result register holds a result |
| out_ready_i | input | 1 | Consumer takes the result |
| res_a_o | output | 32 | Pack: packed halves. Unpack: lane-0 single |
| res_b_o | output | 32 | Pack: zero. Unpack: lane-1 single |

## Verification
The two functions that can fall in the same cycle are draining the held result and accepting the next operation. To provoke this, the bench stalls a result with `out_ready_i` low while a second request waits, then raises `out_ready_i`. It judges the handover by three observations: `in_ready_o` must rise within that cycle, the old result must stay unchanged during the stall, and the new result must replace it on the very next cycle with no empty cycle between.

// File: rtl/hconv_pkg.sv
package hconv_pkg;
  localparam int unsigned SP_W    = 32;
  localparam int unsigned HP_W    = 16;
  localparam int unsigned LANES   = SP_W / HP_W;
  localparam int unsigned SP_EXP  = 8;
  localparam int unsigned SP_FRAC = 23;
  localparam int unsigned HP_EXP  = 5;
  localparam int unsigned HP_FRAC = 10;
  localparam int unsigned SP_BIAS = 127;
  localparam int unsigned HP_BIAS = 15;
  localparam int unsigned BIAS_D  = SP_BIAS - HP_BIAS;

  typedef enum logic {
    OP_PACK   = 1'b0,
    OP_UNPACK = 1'b1
  } conv_op_e;

  typedef struct packed {
    logic               sgn;
    logic [SP_EXP-1:0]  exp;
    logic [SP_FRAC-1:0] frac;
  } sp_t;

  typedef struct packed {
    logic               sgn;
    logic [HP_EXP-1:0]  exp;
    logic [HP_FRAC-1:0] frac;
  } hp_t;
endpackage

// File: rtl/hconv_narrow.sv
module hconv_narrow
  import hconv_pkg::*;
(
  input  logic [SP_W-1:0] f_i,
  input  logic            keep_sub_i,
  output logic [HP_W-1:0] h_o
);
  localparam int unsigned DROP   = SP_FRAC - HP_FRAC;        // 13
  localparam int unsigned SIG_W  = SP_FRAC + 1;              // 24
  localparam int unsigned MAXSH  = SIG_W + 2;                // 26
  localparam int unsigned EXT_W  = SIG_W + MAXSH;            // 50
  localparam logic [SP_EXP-1:0] E_OVF = SP_EXP'(BIAS_D + 31);  // 143
  localparam logic [SP_EXP-1:0] E_NRM = SP_EXP'(BIAS_D + 1);   // 113
  localparam logic [SP_EXP-1:0] E_SUB = SP_EXP'(SP_BIAS - 1);  // 126

  sp_t                 f;
  logic [SP_EXP-1:0]   he8;
  logic                n_g, n_st, n_up;
  logic [HP_W-1:0]     n_sum;
  logic [SP_EXP-1:0]   sh8;
  logic [5:0]          shc;
  logic [EXT_W-1:0]    ext;
  logic [HP_FRAC-1:0]  q;
  logic                s_g, s_st, s_up;
  logic [HP_FRAC:0]    s_sum;

  assign f = sp_t'(f_i);

  // normal-range path
  always_comb begin
    he8   = f.exp - SP_EXP'(BIAS_D);
    n_g   = f.frac[DROP-1];
    n_st  = |f.frac[DROP-2:0];
    n_up  = n_g & (n_st | f.frac[DROP]);
    n_sum = {1'b0, he8[HP_EXP-1:0], f.frac[SP_FRAC-1:DROP]} + HP_W'(n_up);
  end

  // subnormal-range path: align significand to 2^-24 units
  always_comb begin
    sh8   = E_SUB - f.exp;
    shc   = (sh8 > SP_EXP'(MAXSH)) ? 6'(MAXSH) : sh8[5:0];
    ext   = {1'b1, f.frac, {MAXSH{1'b0}}} >> shc;
    q     = ext[MAXSH +: HP_FRAC];
    s_g   = ext[MAXSH-1];
    s_st  = |ext[MAXSH-2:0];
    s_up  = s_g & (s_st | q[0]);
    s_sum = {1'b0, q} + (HP_FRAC+1)'(s_up);
  end

  always_comb begin
    if (&f.exp) begin
      if (f.frac == '0) h_o = {f.sgn, {HP_EXP{1'b1}}, {HP_FRAC{1'b0}}};
      else              h_o = {f.sgn, {HP_EXP{1'b1}}, 1'b1, f.frac[SP_FRAC-2:DROP]};
    end else if (f.exp == '0) begin
      h_o = {f.sgn, {(HP_W-1){1'b0}}};
    end else if (f.exp >= E_OVF) begin
      h_o = {f.sgn, {HP_EXP{1'b1}}, {HP_FRAC{1'b0}}};
    end else if (f.exp >= E_NRM) begin
      h_o = {f.sgn, n_sum[HP_W-2:0]};
    end else if (!keep_sub_i && !s_sum[HP_FRAC]) begin
      h_o = {f.sgn, {(HP_W-1){1'b0}}};
    end else begin
      h_o = {f.sgn, {(HP_EXP-1){1'b0}}, s_sum};
    end
  end
endmodule

// File: rtl/hconv_widen.sv
module hconv_widen
  import hconv_pkg::*;
(
  input  logic [HP_W-1:0] h_i,
  input  logic            keep_sub_i,
  output logic [SP_W-1:0] f_o
);
  localparam int unsigned DROP  = SP_FRAC - HP_FRAC;
  localparam int unsigned SIG_W = SP_FRAC + 1;
  localparam logic [SP_EXP-1:0] E_LOW = SP_EXP'(BIAS_D + 1 - HP_FRAC);  // 103

  hp_t              h;
  logic [3:0]       lead;
  logic [4:0]       shamt;
  logic [SIG_W-1:0] norm;

  assign h = hp_t'(h_i);

  always_comb begin
    lead = '0;
    for (int i = 0; i < int'(HP_FRAC); i++) begin
      if (h.frac[i]) lead = 4'(i);
    end
    shamt = 5'(SP_FRAC) - {1'b0, lead};
    norm  = {{(SIG_W-HP_FRAC){1'b0}}, h.frac} << shamt;
  end

  always_comb begin
    if (&h.exp) begin
      if (h.frac == '0) f_o = {h.sgn, {SP_EXP{1'b1}}, {SP_FRAC{1'b0}}};
      else              f_o = {h.sgn, {SP_EXP{1'b1}}, 1'b1, h.frac[HP_FRAC-2:0], {DROP{1'b0}}};
    end else if (h.exp == '0) begin
      if (h.frac == '0 || !keep_sub_i) f_o = {h.sgn, {(SP_W-1){1'b0}}};
      else f_o = {h.sgn, E_LOW + SP_EXP'(lead), norm[SP_FRAC-1:0]};
    end else begin
      f_o = {h.sgn, SP_EXP'(h.exp) + SP_EXP'(BIAS_D), h.frac, {DROP{1'b0}}};
    end
  end
endmodule

// File: rtl/half_pack_unit.sv
module half_pack_unit
  import hconv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            op_unpack_i,
  input  logic            keep_sub_i,
  input  logic [SP_W-1:0] a_i,
  input  logic [SP_W-1:0] b_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [SP_W-1:0] res_a_o,
  output logic [SP_W-1:0] res_b_o
);
  logic [SP_W-1:0] pk_src [LANES];
  logic [HP_W-1:0] pk_half[LANES];
  logic [SP_W-1:0] up_full[LANES];
  logic [SP_W-1:0] pk_word;
  logic [SP_W-1:0] nxt_a, nxt_b;
  logic            accept;
  logic            vld_q;
  logic [SP_W-1:0] ra_q, rb_q;
  conv_op_e        op;

  assign pk_src[0] = a_i;
  assign pk_src[1] = b_i;
  assign op        = conv_op_e'(op_unpack_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    hconv_narrow i_narrow (
      .f_i       (pk_src[l]),
      .keep_sub_i(keep_sub_i),
      .h_o       (pk_half[l])
    );
    hconv_widen i_widen (
      .h_i       (a_i[l*HP_W +: HP_W]),
      .keep_sub_i(keep_sub_i),
      .f_o       (up_full[l])
    );
    assign pk_word[l*HP_W +: HP_W] = pk_half[l];
  end

  always_comb begin
    if (op == OP_UNPACK) begin
      nxt_a = up_full[0];
      nxt_b = up_full[1];
    end else begin
      nxt_a = pk_word;
      nxt_b = '0;
    end
  end

  assign in_ready_o = !vld_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ra_q  <= '0;
      rb_q  <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      ra_q  <= nxt_a;
      rb_q  <= nxt_b;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign res_a_o     = ra_q;
  assign res_b_o     = rb_q;
endmodule

// File: rtl/half_pack_unit_chk.sv
module half_pack_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        op_unpack_i,
  input logic [31:0] a_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] res_a_o,
  input logic [31:0] res_b_o
);
  logic fire;
  assign fire = in_valid_i && in_ready_o;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_a_o) && $stable(res_b_o));

  p_full_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);

  p_pack_hi_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !op_unpack_i |=> res_b_o == 32'h0);

  p_sp_sub_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !op_unpack_i && a_i[30:23] == 8'h00 |=>
      res_a_o[14:0] == 15'h0 && res_a_o[15] == $past(a_i[31]));

  p_nan_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !op_unpack_i && a_i[30:23] == 8'hff && a_i[22:0] != 23'h0 |=>
      res_a_o[14:9] == 6'h3f && res_a_o[15] == $past(a_i[31]));

  p_hzero_widen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && op_unpack_i && a_i[14:0] == 15'h0 |=>
      res_a_o[30:0] == 31'h0 && res_a_o[31] == $past(a_i[15]));
endmodule

bind half_pack_unit half_pack_unit_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .op_unpack_i(op_unpack_i),
  .a_i        (a_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .res_a_o    (res_a_o),
  .res_b_o    (res_b_o)
);

// File: tb/test_half_pack_unit.sv
module test_half_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, op_unpack = 1'b0, keep_sub = 1'b1, out_ready = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic        in_ready, out_valid;
  logic [31:0] res_a, res_b;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  half_pack_unit i_half_pack_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_unpack_i(op_unpack), .keep_sub_i(keep_sub), .a_i(a), .b_i(b),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .res_a_o(res_a), .res_b_o(res_b)
  );

  // {tag, op_unpack, keep_sub, a, b, exp_a, exp_b}
  localparam int NV = 19;
  localparam logic [24+2+128-1:0] VEC [NV] = '{
    {"R1 ", 2'b01, 32'h3F800000, 32'hC0000000, 32'hC0003C00, 32'h0},
    {"R1 ", 2'b01, 32'h3DCCCCCD, 32'h477FE000, 32'h7BFF2E66, 32'h0},
    {"R1 ", 2'b01, 32'h3F801000, 32'h3F803000, 32'h3C023C00, 32'h0},
    {"R8 ", 2'b01, 32'h3FFFF000, 32'h477FF000, 32'h7C004000, 32'h0},
    {"R3 ", 2'b01, 32'h33800000, 32'h38000000, 32'h02000001, 32'h0},
    {"R4 ", 2'b00, 32'h33800000, 32'h38000000, 32'h00000000, 32'h0},
    {"R8 ", 2'b00, 32'h387FF000, 32'hB3800000, 32'h80000400, 32'h0},
    {"R5 ", 2'b01, 32'h00000001, 32'h80400000, 32'h80000000, 32'h0},
    {"R5 ", 2'b00, 32'h80000001, 32'hB2800000, 32'h80008000, 32'h0},
    {"R6 ", 2'b01, 32'h7F800000, 32'hFF800000, 32'hFC007C00, 32'h0},
    {"R7 ", 2'b01, 32'h7FC00000, 32'hFF800001, 32'hFE007E00, 32'h0},
    {"R6 ", 2'b00, 32'hC7800000, 32'h4F000000, 32'h7C00FC00, 32'h0},
    {"R2 ", 2'b11, 32'hC0003C00, 32'hDEADBEEF, 32'h3F800000, 32'hC0000000},
    {"R2 ", 2'b11, 32'h2E667BFF, 32'h12345678, 32'h477FE000, 32'h3DCCC000},
    {"R3 ", 2'b11, 32'h03FF0001, 32'hFFFFFFFF, 32'h33800000, 32'h387FC000},
    {"R4 ", 2'b10, 32'h83FF8001, 32'h0, 32'h80000000, 32'h80000000},
    {"R6 ", 2'b11, 32'hFC007C00, 32'h0, 32'h7F800000, 32'hFF800000},
    {"R7 ", 2'b11, 32'hFC017E00, 32'h0, 32'h7FC00000, 32'hFFC02000},
    {"R4 ", 2'b10, 32'h04000200, 32'h0, 32'h00000000, 32'h38800000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", {62'h0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {op_unpack, keep_sub, a, b} = VEC[i][129:64];
      in_valid = 1'b1;
      @(posedge clk); #1 in_valid = 1'b0;
      @(negedge clk);
      check(string'(VEC[i][153:130]), {res_a, res_b}, VEC[i][63:0]);
      check("R11 valid", {63'h0, out_valid}, 64'h1);
    end
    @(negedge clk);
    check("R11 drained", {63'h0, out_valid}, 64'h0);

    // stall then handover
    out_ready = 1'b0; op_unpack = 1'b0; keep_sub = 1'b1;
    a = 32'h3F800000; b = 32'h40000000; in_valid = 1'b1;
    @(posedge clk); #1;
    a = 32'h3C003C00; op_unpack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 hold", {res_a, res_b}, {32'h40003C00, 32'h0});
      check("R10 blocked", {62'h0, out_valid, in_ready}, 64'h2);
    end
    out_ready = 1'b1;
    #1 check("R11 drain-ready", {63'h0, in_ready}, 64'h1);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check("R11 handover", {res_a, res_b}, {32'h3F800000, 32'h3F800000});
    check("R11 handover valid", {63'h0, out_valid}, 64'h1);

    // second-lane input ignored in unpack
    a = 32'h3C003C00; b = 32'hFFFFFFFF; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check("R2 b ignored", {res_a, res_b}, {32'h3F800000, 32'h3F800000});
    @(negedge clk);
    finish_run();
  end
endmodule